// File: doc/BRIEF.md
# Primary Slot Memory Mapper

This block sits between a CPU with an 8-bit data bus and a 16-bit address bus and its backing memories. It splits the address space into four 16 KiB pages and lets each page choose one of four primary slots independently. The choice comes from an 8-bit slot map that software loads through a parallel-port write strobe. Each page reads its 2-bit slot number from its own field of that map.

For every access the block resolves the current page and slot into a one-hot region select. The regions are the main system ROM, the interpreter ROM, the 64 KiB RAM, or nothing. The block also drives the matching ROM or RAM address and generates the RAM write enable. It returns the selected read data to the CPU. Regions with no memory behind them read as 0xFF. Writes that land on ROM or on empty regions are dropped.

Slot 3 covers the whole RAM. Slot 0 carries the main ROM in page 0 and the interpreter ROM in page 1. Slot 0 pages 2 and 3, and all of slots 1 and 2, are empty.

Top module: `slot_mapper`

## Requirements
- R1: The page index is `cpu_addr[15:14]`, and `cpu_addr[13:0]` is the offset within the page. While a ROM region is selected, `rom_addr` equals that offset.
- R2: Page n takes its slot number from bits [2n+1:2n] of the slot map. Page 0 uses bits [1:0].
- R3: Slot 3 selects RAM on every page, shown as `region_sel` bit 2. `ram_addr` is page×16384 + offset. Reads return `ram_rdata`, and `ram_we` follows `cpu_wr`.
- R4: Slot 0 page 0 selects the main ROM (`region_sel` bit 0) and returns `main_rom_rdata`. Slot 0 page 1 selects the interpreter ROM (`region_sel` bit 1) and returns `interp_rom_rdata`.
- R5: Slots 1 and 2 on any page, and slot 0 on pages 2 and 3, select no memory (`region_sel` bit 3). Reads there return 0xFF.
- R6: A write to a ROM or empty region never raises `ram_we`, and the RAM contents stay unchanged.
- R7: Reset clears the slot map, so all four pages select slot 0.
- R8: The slot map loads `sel_data` on the clock edge where `sel_wr` is high. An access in that same cycle still uses the previous map.
- R9: `region_sel` always has exactly one bit set.
- R10: While `cpu_rd` is low, `cpu_rdata` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| sel_wr | input | 1 | Parallel-port write strobe that loads the slot map |
| sel_data | input | 8 | New slot map value |
| main_rom_rdata | input | 8 | Read data from the main ROM |
| interp_rom_rdata | input | 8 | Read data from the interpreter ROM |
| ram_rdata | input | 8 | Read data from the RAM |
| region_sel | output | 4 | One-hot region: bit0 main ROM, bit1 interpreter ROM, bit2 RAM, bit3 none |
| rom_addr | output | 14 | Offset into the selected ROM |
| ram_addr | output | 16 | RAM byte address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
The first stimulus uses the reset map and sweeps reads and writes over all four pages. This separates the two ROMs, the empty upper pages and the write discard. Next comes an all-RAM map with writes and read-back on every page; this shows whether the page bits reach the RAM address. Mixed maps such as one slot per page, and the same set in reverse order, reveal swapped or shifted 2-bit fields. A map load combined with an access in the same cycle shows whether the old map is used. A long random run then mixes map loads, reads, writes and idle cycles at clustered addresses. A behavioural reference model of the map and the RAM is compared against the outputs on every clock.

// File: rtl/slot_map_pkg.sv
package slot_map_pkg;

  // Region index; region_sel bit position equals this value.
  typedef enum logic [1:0] {
    REG_MAIN   = 2'd0,
    REG_INTERP = 2'd1,
    REG_RAM    = 2'd2,
    REG_NONE   = 2'd3
  } region_e;

  localparam int REGION_N = 4;

endpackage

// File: rtl/reset_sync.sv
module reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];

endmodule

// File: rtl/slot_select_reg.sv
module slot_select_reg #(
  parameter int MAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MAP_W-1:0] load_data,
  output logic [MAP_W-1:0] map
);

  logic [MAP_W-1:0] map_q;
  logic [MAP_W-1:0] map_d;

  always_comb begin
    map_d = map_q;
    if (load) map_d = load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    map_q <= '0;
    else if (load) map_q <= map_d;
  end

  assign map = map_q;

  // R8
  map_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (map == $past(load_data)));

  // R8
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(map));

endmodule

// File: rtl/page_decoder.sv
module page_decoder #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 2,
  parameter int SLOT_W = 2,
  localparam int N_PAGES = 1 << PAGE_W,
  localparam int OFF_W   = ADDR_W - PAGE_W,
  localparam int MAP_W   = SLOT_W * N_PAGES
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [MAP_W-1:0]  map,
  output logic [PAGE_W-1:0] page,
  output logic [OFF_W-1:0]  offset,
  output logic [SLOT_W-1:0] slot
);

  logic [SLOT_W-1:0] page_slot [N_PAGES];

  genvar g;
  generate
    for (g = 0; g < N_PAGES; g++) begin : g_field
      assign page_slot[g] = map[g*SLOT_W +: SLOT_W];
    end
  endgenerate

  always_comb begin
    page   = addr[ADDR_W-1 -: PAGE_W];
    offset = addr[OFF_W-1:0];
    slot   = page_slot[page];
  end

endmodule

// File: rtl/region_resolver.sv
module region_resolver
  import slot_map_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 2,
  parameter int SLOT_W      = 2,
  parameter int RAM_SLOT    = 3,
  parameter int ROM_SLOT    = 0,
  parameter int MAIN_PAGE   = 0,
  parameter int INTERP_PAGE = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PAGE_W-1:0]   page,
  input  logic [SLOT_W-1:0]   slot,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  input  logic [DATA_W-1:0]   main_rom_rdata,
  input  logic [DATA_W-1:0]   interp_rom_rdata,
  input  logic [DATA_W-1:0]   ram_rdata,
  output logic [REGION_N-1:0] region_sel,
  output logic                ram_we,
  output logic [DATA_W-1:0]   cpu_rdata
);

  region_e          region;
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    if (slot == SLOT_W'(RAM_SLOT))
      region = REG_RAM;
    else if (slot == SLOT_W'(ROM_SLOT) && page == PAGE_W'(MAIN_PAGE))
      region = REG_MAIN;
    else if (slot == SLOT_W'(ROM_SLOT) && page == PAGE_W'(INTERP_PAGE))
      region = REG_INTERP;
    else
      region = REG_NONE;
  end

  always_comb begin
    region_sel         = '0;
    region_sel[region] = 1'b1;
  end

  always_comb begin
    case (region)
      REG_MAIN:   sel_data = main_rom_rdata;
      REG_INTERP: sel_data = interp_rom_rdata;
      REG_RAM:    sel_data = ram_rdata;
      default:    sel_data = '1;
    endcase
    cpu_rdata = cpu_rd ? sel_data : '1;
  end

  assign ram_we = cpu_wr && (region == REG_RAM);

  // R9
  region_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(region_sel) == 1);

  // R5
  empty_reads_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region_sel[REG_NONE] |-> (cpu_rdata == '1));

  // R6
  rom_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && slot != SLOT_W'(RAM_SLOT)) |-> !ram_we);

  // R10
  idle_bus_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> (cpu_rdata == '1));

endmodule

// File: rtl/slot_mapper.sv
module slot_mapper
  import slot_map_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 2,
  parameter int SLOT_W      = 2,
  parameter int RAM_SLOT    = 3,
  parameter int ROM_SLOT    = 0,
  parameter int MAIN_PAGE   = 0,
  parameter int INTERP_PAGE = 1,
  localparam int N_PAGES = 1 << PAGE_W,
  localparam int OFF_W   = ADDR_W - PAGE_W,
  localparam int MAP_W   = SLOT_W * N_PAGES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic                sel_wr,
  input  logic [MAP_W-1:0]    sel_data,
  input  logic [DATA_W-1:0]   main_rom_rdata,
  input  logic [DATA_W-1:0]   interp_rom_rdata,
  input  logic [DATA_W-1:0]   ram_rdata,
  output logic [REGION_N-1:0] region_sel,
  output logic [OFF_W-1:0]    rom_addr,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic                ram_we,
  output logic [DATA_W-1:0]   ram_wdata,
  output logic [DATA_W-1:0]   cpu_rdata
);

  logic              rst_int_n;
  logic [MAP_W-1:0]  slot_map;
  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  offset;
  logic [SLOT_W-1:0] slot;

  reset_sync #(.STAGES(2)) u_reset_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  slot_select_reg #(.MAP_W(MAP_W)) u_slot_select_reg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (sel_wr),
    .load_data (sel_data),
    .map       (slot_map)
  );

  page_decoder #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .SLOT_W (SLOT_W)
  ) u_page_decoder (
    .addr   (cpu_addr),
    .map    (slot_map),
    .page   (page),
    .offset (offset),
    .slot   (slot)
  );

  region_resolver #(
    .DATA_W      (DATA_W),
    .PAGE_W      (PAGE_W),
    .SLOT_W      (SLOT_W),
    .RAM_SLOT    (RAM_SLOT),
    .ROM_SLOT    (ROM_SLOT),
    .MAIN_PAGE   (MAIN_PAGE),
    .INTERP_PAGE (INTERP_PAGE)
  ) u_region_resolver (
    .clk              (clk),
    .rst_n            (rst_int_n),
    .page             (page),
    .slot             (slot),
    .cpu_rd           (cpu_rd),
    .cpu_wr           (cpu_wr),
    .main_rom_rdata   (main_rom_rdata),
    .interp_rom_rdata (interp_rom_rdata),
    .ram_rdata        (ram_rdata),
    .region_sel       (region_sel),
    .ram_we           (ram_we),
    .cpu_rdata        (cpu_rdata)
  );

  assign rom_addr  = offset;
  assign ram_addr  = {page, offset};
  assign ram_wdata = cpu_wdata;

  // R3
  ram_we_path_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ram_we |-> (region_sel[REG_RAM] && cpu_wr && ram_addr == cpu_addr));

endmodule

// File: tb/slot_mapper_bench.sv
module slot_mapper_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata;
  logic        sel_wr;
  logic [7:0]  sel_data;
  logic [7:0]  main_rom_rdata, interp_rom_rdata, ram_rdata;
  logic [3:0]  region_sel;
  logic [13:0] rom_addr;
  logic [15:0] ram_addr;
  logic        ram_we;
  logic [7:0]  ram_wdata, cpu_rdata;

  int checks = 0;
  int fails  = 0;
  bit chk_en = 1'b0;
  bit done   = 1'b0;

  // backing RAM seen by the design, and the bench's own expected RAM
  logic [7:0] bram    [0:65535];
  logic [7:0] ref_mem [0:65535];
  logic [7:0] ref_map;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_mapper u_slot_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .sel_wr(sel_wr), .sel_data(sel_data),
    .main_rom_rdata(main_rom_rdata), .interp_rom_rdata(interp_rom_rdata),
    .ram_rdata(ram_rdata), .region_sel(region_sel), .rom_addr(rom_addr),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .cpu_rdata(cpu_rdata)
  );

  // behavioural memories
  assign main_rom_rdata   = rom_addr[7:0] ^ 8'h3C;
  assign interp_rom_rdata = rom_addr[13:6] ^ 8'h96;
  assign ram_rdata        = bram[ram_addr];
  always @(posedge clk) if (ram_we) bram[ram_addr] <= ram_wdata;

  function automatic int exp_slot(input logic [7:0] m, input logic [15:0] a);
    return int'((m >> (2 * a[15:14])) & 8'h3);
  endfunction

  // expected region index: 0 main, 1 interp, 2 ram, 3 none
  function automatic int exp_region(input logic [7:0] m, input logic [15:0] a);
    int s = exp_slot(m, a);
    if (s == 3) return 2;
    if (s == 0 && a[15:14] == 2'd0) return 0;
    if (s == 0 && a[15:14] == 2'd1) return 1;
    return 3;
  endfunction

  // reference model state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_map <= 8'h00;
    else if (sel_wr) ref_map <= sel_data;
  end
  always @(posedge clk)
    if (chk_en && cpu_wr && exp_region(ref_map, cpu_addr) == 2)
      ref_mem[cpu_addr] <= cpu_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (addr %04h map %02h t=%0t)",
               req, act, exp, cpu_addr, ref_map, $time);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (chk_en) begin
      int r;
      logic [7:0] ed;
      string tag;
      r = exp_region(ref_map, cpu_addr);
      case (r)
        0: begin tag = "R2 R4"; ed = cpu_addr[7:0] ^ 8'h3C; end
        1: begin tag = "R2 R4"; ed = cpu_addr[13:6] ^ 8'h96; end
        2: begin tag = "R2 R3"; ed = ref_mem[cpu_addr]; end
        default: begin tag = "R2 R5"; ed = 8'hFF; end
      endcase
      if (sel_wr) tag = {"R8 ", tag};
      check(tag, region_sel, 32'(1 << r));
      check("R9", $countones(region_sel), 1);
      if (r < 2) check("R1", rom_addr, cpu_addr[13:0]);
      if (r == 2) check("R3", ram_addr, cpu_addr);
      check(r == 2 ? "R3" : "R6", ram_we, (cpu_wr && r == 2));
      if (cpu_rd) check(tag, cpu_rdata, ed);
      else        check("R10", cpu_rdata, 8'hFF);
    end
  end

  task automatic op(input logic [15:0] a, input bit rd, input bit wr,
                    input logic [7:0] wd, input bit sw, input logic [7:0] sd);
    @(posedge clk); #1;
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    sel_wr = sw; sel_data = sd;
  endtask

  task automatic rd(input logic [15:0] a);
    op(a, 1, 0, 8'h00, 0, 8'h00);
  endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    op(a, 0, 1, d, 0, 8'h00);
  endtask
  task automatic setmap(input logic [7:0] m);
    op(16'h0000, 0, 0, 8'h00, 1, m);
  endtask

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 65536; i++) begin
      bram[i]    = 8'(i * 7 + 1);
      ref_mem[i] = 8'(i * 7 + 1);
    end
    rst_n = 1'b0; cpu_addr = 16'h0000; cpu_rd = 1'b1; cpu_wr = 1'b0;
    cpu_wdata = 8'h00; sel_wr = 1'b0; sel_data = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: in reset the map is cleared, page 0 selects the main ROM
    check("R7", region_sel, 4'b0001);
    #1 cpu_addr = 16'h4000;
    #1 check("R7", region_sel, 4'b0010);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 cpu_rd = 1'b0;
    chk_en = 1'b1;

    // reset map: sweep all pages, R7 after release
    for (int p = 0; p < 4; p++) begin
      rd(16'(p * 16384 + 16'h0123));
      rd(16'(p * 16384 + 16'h3FFF));
      wr(16'(p * 16384 + 16'h0010), 8'hAA);  // R6: ROM or empty, dropped
    end

    // all RAM
    setmap(8'hFF);
    for (int p = 0; p < 4; p++) begin
      wr(16'(p * 16384 + 16'h0010), 8'(8'h50 + p));
      rd(16'(p * 16384 + 16'h0010));
    end
    // R6: writes under ROM/empty mapping must not touch RAM
    setmap(8'h00);
    wr(16'h0010, 8'hEE);
    wr(16'h8010, 8'hEE);
    wr(16'hC010, 8'hEE);
    setmap(8'hFF);
    rd(16'h0010); rd(16'h8010); rd(16'hC010);

    // R2: one slot per page, then reversed
    setmap(8'hE4);
    for (int p = 0; p < 4; p++) rd(16'(p * 16384 + 16'h0200));
    setmap(8'h1B);
    for (int p = 0; p < 4; p++) rd(16'(p * 16384 + 16'h0200));

    // R8: load and access in the same cycle use the old map
    setmap(8'h00);
    op(16'h0000, 1, 0, 8'h00, 1, 8'h03);  // still main ROM this cycle
    rd(16'h0000);                          // now RAM
    op(16'h0010, 0, 1, 8'h77, 1, 8'h00);  // write goes to RAM under old map
    setmap(8'h03);
    rd(16'h0010);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      int k;
      k = $urandom_range(0, 9);
      if ($urandom_range(0, 1) == 1) a = {2'($urandom), 10'h000, 4'($urandom)};
      else a = 16'($urandom);
      case (k)
        0:       op(a, $urandom_range(0,1), 0, 8'h00, 1, 8'($urandom));
        1, 2, 3: wr(a, 8'($urandom));
        4:       op(a, 0, 0, 8'h00, 0, 8'h00);
        default: rd(a);
      endcase
    end

    @(posedge clk); #1;
    cpu_rd = 1'b0; cpu_wr = 1'b0; sel_wr = 1'b0;
    @(negedge clk);
    done = 1'b1;
    chk_en = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule